// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block receives write-only serial frames on three wires: an active-low frame select, a serial clock and a serial data line. It sits in front of a converter command decoder. All three wires are brought into the system clock domain through synchronizer chains. Frame-select and serial-clock edges are then found from the synchronized samples. Each frame is 32 bits long and arrives most significant bit first. A data bit is taken on every falling edge of the serial clock while the frame select is low.

When the 32nd bit arrives, the receiver publishes the whole word and splits it into a command field, an address field and a data field. It marks the new word with a strobe one system clock wide. The word is held until the next complete frame. If the frame select rises before the 32nd bit, the partial frame is dropped without any sign at the outputs. Once a frame has completed, the receiver ignores further serial activity until the frame select has gone high and then low again.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, `frame_valid` is 0 and `frame_word` and all field outputs are 0.
- R2: Serial clock falling edges seen while the frame select is high are ignored: they produce no strobe and leave `frame_word` unchanged.
- R3: A frame starts on a falling edge of the frame select. The first data bit received ends up at bit 31 of `frame_word`, and later bits fill the lower positions in turn. The word is published on the 32nd serial clock falling edge.
- R4: `frame_cmd` is `frame_word[27:24]`, `frame_addr` is `frame_word[23:20]` and `frame_data` is `frame_word[19:0]`. Bits 31:28 go to no field.
- R5: Each completed frame gives exactly one `frame_valid` pulse, and that pulse is exactly one system clock wide.
- R6: If the frame select rises after 1 to 31 serial clock falling edges, there is no strobe and `frame_word` keeps its old value. The next full frame is received correctly, starting again from bit 31.
- R7: After a frame completes with the frame select still low, further serial clock edges give no strobe and do not change `frame_word`.
- R8: After a completed frame, a new frame is received only after the frame select goes high and then low again.
- R9: `frame_valid` rises on the third rising edge of the system clock after the 32nd serial clock falling edge appears at the pins.
- R10: `frame_word` changes only in the cycle in which `frame_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous to clk |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| frame_valid | output | 1 | One-cycle strobe marking a newly completed frame |
| frame_word | output | 32 | Last completed frame |
| frame_cmd | output | 4 | Command field of the last frame |
| frame_addr | output | 4 | Address field of the last frame |
| frame_data | output | 20 | Data and option bits of the last frame |

## Verification
A bit counter that is off by one shows up at the ports as a word shifted by one position, or as a strobe that comes one serial bit early or late. This is visible on the first frame after the fault. A phase register that is not cleared on an abort makes the next frame come out misaligned. A receiver that wrongly leaves its hold phase shows up as a second strobe within 32 serial clocks of the first. A synchronizer chain of the wrong depth moves the strobe away from the exact cycle the latency check samples.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam int FRAME_W   = 32;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int FIELD_W   = 4;
    localparam int CMD_LSB   = 24;
    localparam int ADDR_LSB  = 20;
    localparam int PAYLOAD_W = 20;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_W-1:0]   shreg;
        logic [FRAME_W-1:0]   word;
        logic                 valid;
    } core_state_t;

endpackage

// File: rtl/frame_rx_sync.sv
module frame_rx_sync #(
    parameter int              LANES  = 3,
    parameter int              STAGES = 2,
    parameter logic [LANES-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[l]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[l]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[l] = chain_q[LAST];
    end

endmodule

// File: rtl/frame_rx_edge.sv
module frame_rx_edge #(
    parameter int              LANES   = 2,
    parameter logic [LANES-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] level_i,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);

    logic [LANES-1:0] prev_d;
    logic [LANES-1:0] prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_det
        assign rise_o[l] = level_i[l] & ~prev_q[l];
        assign fall_o[l] = ~level_i[l] & prev_q[l];
    end

endmodule

// File: rtl/frame_rx_core.sv
module frame_rx_core
    import frame_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_fall_i,
    input  logic                sel_rise_i,
    input  logic                sck_fall_i,
    input  logic                dat_i,
    output logic                valid_o,
    output logic [FRAME_W-1:0]  word_o,
    output phase_e              phase_o,
    output logic [CNT_W-1:0]    cnt_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    core_state_t st_d;
    core_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (sel_fall_i) begin
                    st_d.phase = PH_SHIFT;
                    st_d.cnt   = '0;
                    st_d.shreg = '0;
                end
            end
            PH_SHIFT: begin
                if (sel_rise_i) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.shreg = '0;
                end else if (sck_fall_i) begin
                    if (st_q.cnt == LAST_BIT) begin
                        st_d.word  = {st_q.shreg[FRAME_W-2:0], dat_i};
                        st_d.valid = 1'b1;
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = '0;
                        st_d.shreg = '0;
                    end else begin
                        st_d.shreg = {st_q.shreg[FRAME_W-2:0], dat_i};
                        st_d.cnt   = st_q.cnt + CNT_ONE;
                    end
                end
            end
            PH_HOLD: begin
                if (sel_rise_i) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
                st_d.shreg = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
            st_q.word  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;
    assign phase_o = st_q.phase;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
    import frame_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_sel_n,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    output logic                  frame_valid,
    output logic [FRAME_W-1:0]    frame_word,
    output logic [FIELD_W-1:0]    frame_cmd,
    output logic [FIELD_W-1:0]    frame_addr,
    output logic [PAYLOAD_W-1:0]  frame_data
);

    localparam int IDX_SEL = 2;
    localparam int IDX_SCK = 1;
    localparam int IDX_DAT = 0;

    logic [2:0]       pins;
    logic [2:0]       pins_s;
    logic [1:0]       lvl;
    logic [1:0]       rise;
    logic [1:0]       fall;
    logic             sel_rise;
    logic             sel_fall;
    logic             sck_fall;
    phase_e           core_phase;
    logic [CNT_W-1:0] core_cnt;

    assign pins = {ser_sel_n, ser_clk, ser_dat};

    frame_rx_sync #(
        .LANES   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins),
        .sync_o  (pins_s)
    );

    assign lvl = {pins_s[IDX_SEL], pins_s[IDX_SCK]};

    frame_rx_edge #(
        .LANES   (2),
        .RST_VAL (2'b11)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign sel_rise = rise[1];
    assign sel_fall = fall[1];
    assign sck_fall = fall[0];

    frame_rx_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_fall_i (sel_fall),
        .sel_rise_i (sel_rise),
        .sck_fall_i (sck_fall),
        .dat_i      (pins_s[IDX_DAT]),
        .valid_o    (frame_valid),
        .word_o     (frame_word),
        .phase_o    (core_phase),
        .cnt_o      (core_cnt)
    );

    assign frame_cmd  = frame_word[CMD_LSB +: FIELD_W];
    assign frame_addr = frame_word[ADDR_LSB +: FIELD_W];
    assign frame_data = frame_word[PAYLOAD_W-1:0];

endmodule

// File: rtl/frame_rx_checker.sv
module frame_rx_checker
    import frame_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [FRAME_W-1:0]  frame_word,
    input  phase_e              phase,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  logic                sync_rise,
    input  logic                sync_fall
);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r5_valid_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (phase == PH_HOLD && bit_cnt == '0));

    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_word));

    a_r7_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && !sync_rise) |=> (!frame_valid && phase == PH_HOLD));

    a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT && sync_rise) |=> (!frame_valid && phase == PH_IDLE && bit_cnt == '0));

    a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !sync_fall) |=> (phase == PH_IDLE && !frame_valid));

    a_r3_count_zero_outside_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_SHIFT) |-> (bit_cnt == '0));

endmodule

bind cmd_frame_rx frame_rx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .phase       (core_phase),
    .bit_cnt     (core_cnt),
    .sync_rise   (sel_rise),
    .sync_fall   (sel_fall)
);

// File: tb/test_cmd_frame_rx.sv
`timescale 1ns/1ps
module test_cmd_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdat = 1'b0;
    logic        frame_valid;
    logic [31:0] frame_word;
    logic [3:0]  frame_cmd;
    logic [3:0]  frame_addr;
    logic [19:0] frame_data;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int wide_pulses = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic prev_valid = 1'b0;
    logic [31:0] last_word = '0;

    always #2 clk = ~clk;

    cmd_frame_rx i_cmd_frame_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_sel_n   (sel_n),
        .ser_clk     (sck),
        .ser_dat     (sdat),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .frame_cmd   (frame_cmd),
        .frame_addr  (frame_addr),
        .frame_data  (frame_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (frame_valid) pulses <= pulses + 1;
            if (frame_valid && prev_valid) wide_pulses <= wide_pulses + 1;
        end
        prev_valid <= frame_valid;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sel_low();
        tick(1); sel_n = 1'b0; tick(4);
    endtask

    task automatic sel_high();
        tick(1); sel_n = 1'b1; tick(6);
    endtask

    task automatic clock_bit(input logic b);
        tick(1); sck = 1'b1; sdat = b; tick(4);
        sck = 1'b0; tick(4);
    endtask

    task automatic clock_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) clock_bit(w[31-i]);
    endtask

    task automatic full_frame(input logic [31:0] w, input string req);
        int p0;
        p0 = pulses;
        sel_low();
        clock_bits(w, 32);
        sel_high();
        check(frame_word == w, req, frame_word, w);
        check(pulses == p0 + 1, "R5 one strobe per frame", 32'(pulses - p0), 32'd1);
        // R4: field split, computed arithmetically
        check(frame_cmd == 4'((w >> 24) & 32'hF) && frame_addr == 4'((w >> 20) & 32'hF)
              && frame_data == 20'(w & 32'hFFFFF), "R4 fields",
              {frame_cmd, frame_addr, 4'h0, frame_data}, {4'((w >> 24)), 4'((w >> 20)), 4'h0, 20'(w)});
        last_word = w;
    endtask

    initial begin
        int p0;
        tick(5);
        @(negedge clk);
        // R1: reset state
        check(frame_valid == 1'b0, "R1 valid in reset", 32'(frame_valid), 32'd0);
        check(frame_word == '0, "R1 word in reset", frame_word, 32'd0);
        rst_n = 1'b1;
        tick(4);
        check(frame_valid == 1'b0 && frame_word == '0 && frame_cmd == '0
              && frame_addr == '0 && frame_data == '0, "R1 after reset", frame_word, 32'd0);

        // R3/R4: fixed patterns
        full_frame(32'hFFFF_FFFF, "R3 all ones");
        full_frame(32'h0000_0000, "R3 all zeros");
        full_frame(32'hA5C3_9E17, "R3 mixed");
        full_frame(32'h3C7B_1D02, "R3 field pattern");

        // R3: walking one over every bit position
        for (int k = 0; k < 32; k++) full_frame(32'h1 << k, "R3 walking one");

        // R9: latency of the strobe, R5 width
        sel_low();
        clock_bits(32'h5A5A_0F0F, 31);
        tick(1); sck = 1'b1; sdat = 1'b1; tick(4);
        sck = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(frame_valid == 1'b0, "R9 no strobe after two clocks", 32'(frame_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        check(frame_valid == 1'b1, "R9 strobe on third clock", 32'(frame_valid), 32'd1);
        check(frame_word == 32'h5A5A_0F0F, "R10 word with strobe", frame_word, 32'h5A5A_0F0F);
        @(posedge clk); @(negedge clk);
        check(frame_valid == 1'b0, "R5 strobe one cycle", 32'(frame_valid), 32'd0);
        last_word = 32'h5A5A_0F0F;
        sel_high();

        // R2: serial clock activity with frame select high
        p0 = pulses;
        for (int i = 0; i < 40; i++) clock_bit(i[0]);
        check(pulses == p0, "R2 no strobe while deselected", 32'(pulses - p0), 32'd0);
        check(frame_word == last_word, "R2 word unchanged", frame_word, last_word);

        // R6: abort after every partial length, then a full frame
        for (int n = 1; n < 32; n++) begin
            p0 = pulses;
            sel_low();
            clock_bits(~last_word, n);
            sel_high();
            check(pulses == p0 && frame_word == last_word, "R6 abort silent", frame_word, last_word);
        end
        full_frame(32'hC001_D00D, "R6 frame after aborts");
        sel_low();
        clock_bits(32'hFFFF_FFFF, 17);
        sel_high();
        full_frame(32'h1234_5678, "R6 counter cleared after abort");

        // R7/R8: extra edges with select still low, then re-arm
        sel_low();
        clock_bits(32'h0F1E_2D3C, 32);
        tick(4);
        last_word = 32'h0F1E_2D3C;
        p0 = pulses;
        clock_bits(32'hDEAD_BEEF, 32);
        clock_bits(32'h0000_0001, 8);
        check(pulses == p0, "R7 no second strobe", 32'(pulses - p0), 32'd0);
        check(frame_word == last_word, "R7 word unchanged", frame_word, last_word);
        check(frame_word == 32'h0F1E_2D3C, "R8 no frame without re-arm", frame_word, 32'h0F1E_2D3C);
        sel_high();
        full_frame(32'h8765_4321, "R8 frame after re-arm");

        check(wide_pulses == 0, "R5 no strobe wider than one cycle", 32'(wide_pulses), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule